// File: doc/BRIEF.md
# Prescaled Watchdog Supervisor Timer

This block watches for a stalled program. An instruction-cycle strobe, one clock in every `TICK_DIV` (12 by default), drives a prescaler. The prescaler divides by one of eight powers of two, chosen by three select bits, and each of its wraps advances a `CNT_W`-bit supervision counter (14 bits by default). When that counter rolls over, the block raises a sticky timeout flag. If supervision is enabled, it also issues a one-clock system reset request.

Software controls the block through a single 8-bit control register, using a select line with write and read strobes. Writing the self-clearing clear bit restarts both dividers and drops the flag at the next instruction-cycle strobe. A separate bit decides whether counting continues while the processor reports idle.

Top module: `wdog_prescaled`

## Requirements
- R1: Control register bit positions: bit 7 is enable, bit 6 is clear, bit 5 is keep-running-in-idle, and bits 2..0 are the prescaler select. Bits 4 and 3 always read 0. `rdata` returns the register only while `sel` and `rd_en` are both high, and reads 0 otherwise.
- R2: While `rst_n` is low and after it rises, the register reads 0x00, `timeout_flag` is 0 and `rst_req` is 0. The counters start from zero.
- R3: Select value s gives a prescale ratio of 2^(s+1). The counter therefore overflows `TICK_DIV`·2^(s+1)·2^`CNT_W` clocks after a restart.
- R4: Writing 1 to bit 6 sets it, and it reads back as 1. At the next instruction-cycle strobe the prescaler, the counter and `timeout_flag` are zeroed and bit 6 returns to 0.
- R5: On counter overflow `timeout_flag` becomes 1. It stays 1 until a clear action takes effect.
- R6: `rst_req` is high for exactly one clock, in the same clock as the overflow that sets the flag, and only if bit 7 is 1. With bit 7 at 0 the overflow still sets the flag.
- R7: While `idle` is high and bit 5 is 0, neither the prescaler nor the counter advances. With bit 5 set to 1, counting continues during idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Register select |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| idle | input | 1 | Processor idle indication |
| timeout_flag | output | 1 | Sticky timeout flag |
| rst_req | output | 1 | One-clock system reset request |

## Verification
The assertions assume that `idle`, `sel`, `wr_en`, `rd_en` and `wdata` change only away from the rising clock edge. They also assume that reset is released synchronously to the bench's drive point. The bench drives every input on the falling edge, and it holds write strobes for exactly one clock. The flag-fall property assumes the flag falls only through a clear action. The stimulus never removes the flag any other way, apart from a reset at the start. The bench uses a reduced counter width so that several full timeout periods fit in the run.

// File: rtl/wdog_prescaled.sv
module wdog_prescaled #(
  parameter int TICK_DIV = 12,
  parameter int CNT_W    = 14,
  parameter int PS_BITS  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       idle,
  output logic       timeout_flag,
  output logic       rst_req
);
  localparam int PH_W  = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int PRE_W = 1 << PS_BITS;
  localparam int B_EN  = 7;
  localparam int B_CLR = 6;
  localparam int B_IDL = 5;

  logic [PH_W-1:0]    ph_q;
  logic [PRE_W-1:0]   pre_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [PS_BITS-1:0] ps_q;
  logic               en_q, clr_q, idle_en_q;

  wire tick   = (ph_q == PH_W'(TICK_DIV - 1));
  wire wr_hit = sel & wr_en;
  wire run    = tick & ~clr_q & (~idle | idle_en_q);
  wire [PRE_W-1:0] lim = {PRE_W{1'b1}} >> (PS_BITS'(PRE_W - 1) - ps_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    ph_q <= '0;
    else if (tick) ph_q <= '0;
    else           ph_q <= ph_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q <= 1'b0; clr_q <= 1'b0; idle_en_q <= 1'b0; ps_q <= '0;
    end else if (wr_hit) begin
      en_q      <= wdata[B_EN];
      clr_q     <= wdata[B_CLR];
      idle_en_q <= wdata[B_IDL];
      ps_q      <= wdata[PS_BITS-1:0];
    end else if (tick) begin
      clr_q <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre_q <= '0; cnt_q <= '0; timeout_flag <= 1'b0; rst_req <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (tick & clr_q) begin
        pre_q <= '0; cnt_q <= '0; timeout_flag <= 1'b0;
      end else if (run) begin
        if (pre_q >= lim) begin
          pre_q <= '0;
          cnt_q <= cnt_q + 1'b1;
          if (&cnt_q) begin
            timeout_flag <= 1'b1;
            rst_req      <= en_q;
          end
        end else begin
          pre_q <= pre_q + 1'b1;
        end
      end
    end

  assign rdata = (sel & rd_en)
               ? {en_q, clr_q, idle_en_q, {(5 - PS_BITS){1'b0}}, ps_q}
               : 8'h00;
endmodule

// File: rtl/wdog_prescaled_chk.sv
module wdog_prescaled_chk #(
  parameter int CNT_W = 14,
  parameter int PRE_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             idle,
  input logic             wr_hit,
  input logic             tick,
  input logic             clr_q,
  input logic             en_q,
  input logic             idle_en_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [PRE_W-1:0] pre_q,
  input logic [7:0]       rdata,
  input logic             timeout_flag,
  input logic             rst_req
);
  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[4:3] == 2'b00);

  p_clr_self_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_q && tick && !wr_hit) |=> !clr_q);

  p_clr_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_q && tick) |=> (cnt_q == '0 && pre_q == '0 && !timeout_flag));

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(timeout_flag) |-> $past(clr_q && tick));

  p_req_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  p_req_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (timeout_flag && $past(en_q)));

  p_idle_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !idle_en_q && !clr_q) |=> ($stable(cnt_q) && $stable(pre_q)));
endmodule

bind wdog_prescaled wdog_prescaled_chk #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .idle(idle), .wr_hit(wr_hit), .tick(tick),
  .clr_q(clr_q), .en_q(en_q), .idle_en_q(idle_en_q), .cnt_q(cnt_q),
  .pre_q(pre_q), .rdata(rdata), .timeout_flag(timeout_flag), .rst_req(rst_req)
);

// File: tb/wdog_prescaled_bench.sv
`timescale 1ns/1ps
module wdog_prescaled_bench;
  localparam int TD = 12;
  localparam int CW = 4;

  logic clk = 1'b0, rst_n = 1'b0, sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0, idle = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic timeout_flag, rst_req;

  always #2 clk = ~clk;

  wdog_prescaled #(.TICK_DIV(TD), .CNT_W(CW), .PS_BITS(3)) u_wdog_prescaled (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .idle(idle),
    .timeout_flag(timeout_flag), .rst_req(rst_req));

  int checks = 0, fails = 0, cycles = 0, pulses = 0;
  int m_ph = 0, m_pre = 0, m_cnt = 0, m_ps = 0;
  bit m_en = 0, m_clr = 0, m_ide = 0, m_flag = 0, m_req = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int m_rdata();
    if (sel && rd_en) return {m_en, m_clr, m_ide, 2'b00, m_ps[2:0]};
    return 0;
  endfunction

  always @(posedge clk) begin
    bit tk, o_clr, o_en, o_ide;
    int o_ps;
    tk = (m_ph == TD - 1);
    o_clr = m_clr; o_en = m_en; o_ide = m_ide; o_ps = m_ps;
    if (!rst_n) begin
      m_ph = 0; m_pre = 0; m_cnt = 0; m_ps = 0;
      m_en = 0; m_clr = 0; m_ide = 0; m_flag = 0; m_req = 0;
    end else begin
      m_ph = tk ? 0 : m_ph + 1;
      if (sel && wr_en) begin
        m_en = wdata[7]; m_clr = wdata[6]; m_ide = wdata[5]; m_ps = wdata[2:0];
      end else if (tk) m_clr = 0;
      m_req = 0;
      if (tk && o_clr) begin
        m_pre = 0; m_cnt = 0; m_flag = 0;
      end else if (tk && (!idle || o_ide)) begin
        if (m_pre >= (2 << o_ps) - 1) begin
          m_pre = 0;
          m_cnt = m_cnt + 1;
          if (m_cnt == (1 << CW)) begin
            m_cnt = 0; m_flag = 1; m_req = o_en;
          end
        end else m_pre = m_pre + 1;
      end
    end
    #1;
    if (!done) begin
      cycles++;
      if (rst_req) pulses++;
      chk("R1 rdata", rdata, m_rdata());
      chk("R5 timeout_flag", timeout_flag, m_flag);
      chk("R6 rst_req", rst_req, m_req);
      if (cycles > 190000) begin
        fails++; checks++;
        $display("FAIL watchdog expired actual=%0d expected<190000", cycles);
        finish_run();
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); sel = 1; wr_en = 1; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_n(3);
    rd_en = 1; sel = 1;
    chk("R2 reset rdata", rdata, 0);
    chk("R2 reset flag", timeout_flag, 0);
    rst_n = 1;
    wait_n(2);
    chk("R2 after reset rdata", rdata, 0);

    // R3/R6: enable, ratio 2, overflow after 12*2*16 = 384 clocks
    wr(8'hC0); pulses = 0;
    wait_n(300);
    chk("R3 no early timeout", timeout_flag, 0);
    wait_n(120);
    chk("R3 timeout after period", timeout_flag, 1);
    chk("R6 one pulse when enabled", pulses, 1);

    // R4: clear bit reads 1 then self-clears with flag
    wr(8'h40);
    chk("R4 clear bit visible", rdata[6], 1);
    wait_n(13);
    chk("R4 clear bit self-clears", rdata[6], 0);
    chk("R4 flag cleared", timeout_flag, 0);

    // R1: reserved bits and read gating
    wr(8'h1A);
    chk("R1 reserved bits read 0", rdata, 8'h02);
    rd_en = 0; @(negedge clk);
    chk("R1 no read strobe", rdata, 0);
    rd_en = 1;

    // R6: enable off, ratio 4 -> 768 clocks, flag set, no request
    wr(8'h41); pulses = 0;
    wait_n(800);
    chk("R6 flag without enable", timeout_flag, 1);
    chk("R6 no request when disabled", pulses, 0);

    // R7: idle freeze with bit 5 = 0
    wr(8'h40); wait_n(13);
    idle = 1;
    wait_n(2000);
    chk("R7 frozen in idle", timeout_flag, 0);
    wr(8'hA0); pulses = 0;
    wait_n(420);
    chk("R7 runs in idle when allowed", timeout_flag, 1);
    chk("R7 request in idle", pulses, 1);
    idle = 0;

    // R3: largest ratio 256 -> 49152 clocks
    wr(8'hC7); wait_n(13); pulses = 0;
    wait_n(48000);
    chk("R3 ratio 256 not early", timeout_flag, 0);
    wait_n(1300);
    chk("R3 ratio 256 timeout", timeout_flag, 1);
    chk("R6 single pulse ratio 256", pulses, 1);

    wait_n(2);
    finish_run();
  end
endmodule